// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked system bus and an external asynchronous 32K x 8 static RAM. It accepts one single-beat request at a time through a valid/ready handshake. Each request is either a byte read or a byte write. The block turns it into the chip-select, output-enable and write-enable sequence that the memory needs, with every strobe width counted in clock cycles. Read data comes back on a one-cycle response pulse.

Writes are always framed by write enable inside a chip select that is already held low. The block's own data driver turns on only after write enable has fallen and after the memory has had time to release the bus from an earlier read. A level-sensitive standby input parks the memory deselected for low-power data retention. When standby is released, the block waits a programmable recovery time before it accepts the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After a synchronous reset, chip select, output enable and write enable are all high (inactive), the data driver is off, the response pulse is low, and ready is high when standby is not requested.
- R2: Ready is high only while the block is idle with no standby request. A request is taken on a clock edge where valid and ready are both high. Ready then stays low until that access has finished.
- R3: A read (write flag 0) holds chip select and output enable low with write enable high for RD_CYC cycles on a fixed address. The byte on the memory data input at the end of that window is returned, with the response pulse high for exactly one cycle, RD_CYC cycles after the accepting edge.
- R4: A write (write flag 1) pulls chip select low one cycle before write enable falls. Write enable stays low for at least WP_CYC cycles, and chip select is still low when write enable rises. With DS_CYC no larger than WP_CYC-2, ready returns 1+WP_CYC+DH_CYC cycles after the accepting edge.
- R5: The memory address never changes while chip select and write enable are both low.
- R6: The data driver is on only while chip select is low and output enable is high. It turns on at least one cycle after write enable fell. It stays on for at least DS_CYC cycles before write enable rises and for DH_CYC cycles after.
- R7: After a read releases its strobes, the data driver stays off for at least TA_CYC cycles, even when a write follows at once.
- R8: Output enable and write enable are never low at the same time.
- R9: While standby is requested, chip select stays high, ready stays low and requests are ignored. A standby request outranks a request presented in the same cycle.
- R10: After standby is released, chip select stays high and ready stays low for REC_CYC cycles, counted from the first edge that sees the release.
- R11: A reset in the middle of a write releases every strobe and the driver at the reset edge, and the block comes back idle and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 8 | Read byte |
| standby_req | input | 1 | Hold memory in retention standby |
| mem_addr | output | 15 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data from memory |

## Verification
A wrong state count in a read shows on the very response it affects. If the read samples early, the bench memory has not yet presented valid data, so the byte is wrong. The response also arrives at the wrong cycle. A lost turnaround or a data driver that turns on too early shows as bus contention within a few cycles of the write strobe. Strobe overlap, address movement under a write and a short write pulse are all visible on the memory pins in the cycle they happen. A recovery or standby fault shows as ready or chip select changing early.

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int RD_CYC  = 14,
  parameter int TA_CYC  = 6,
  parameter int WP_CYC  = 11,
  parameter int DS_CYC  = 6,
  parameter int DH_CYC  = 1,
  parameter int REC_CYC = 1_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          standby_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CW  = $clog2(REC_CYC + RD_CYC + WP_CYC + DH_CYC + 2);
  localparam int TW  = $clog2(TA_CYC + 2);
  localparam int DSW = $clog2(DS_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WSETUP, S_WPULSE, S_WHOLD, S_STANDBY, S_RECOVER
  } state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  ta_cnt;
  logic [DSW-1:0] drv_cnt;

  assign req_ready = (st == S_IDLE) && !standby_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      ta_cnt     <= '0;
      drv_cnt    <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (ta_cnt != '0) ta_cnt <= ta_cnt - 1'b1;
      case (st)
        S_IDLE: begin
          cnt     <= '0;
          drv_cnt <= '0;
          if (standby_req) begin
            st <= S_STANDBY;
          end else if (req_valid) begin
            mem_addr <= req_addr;
            mem_cs_n <= 1'b0;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              st         <= S_WSETUP;
            end else begin
              mem_oe_n <= 1'b0;
              st       <= S_READ;
            end
          end
        end
        S_READ: begin
          if (cnt == CW'(RD_CYC - 1)) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            ta_cnt    <= TW'(TA_CYC);
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WSETUP: begin
          mem_we_n <= 1'b0;
          st       <= S_WPULSE;
        end
        S_WPULSE: begin
          if (ta_cnt == '0) mem_dq_oe <= 1'b1;
          if (mem_dq_oe && drv_cnt != DSW'(DS_CYC - 1)) drv_cnt <= drv_cnt + 1'b1;
          if (mem_dq_oe && drv_cnt == DSW'(DS_CYC - 1) && cnt == CW'(WP_CYC - 1)) begin
            mem_we_n <= 1'b1;
            cnt      <= '0;
            st       <= S_WHOLD;
          end else if (cnt != CW'(WP_CYC - 1)) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WHOLD: begin
          if (cnt == CW'(DH_CYC - 1)) begin
            mem_cs_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            st        <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STANDBY: begin
          cnt <= '0;
          if (!standby_req) st <= S_RECOVER;
        end
        S_RECOVER: begin
          if (standby_req) begin
            st <= S_STANDBY;
          end else if (cnt == CW'(REC_CYC - 1)) begin
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sram_async_ctrl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          standby_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n)); // R8
  AST_ADDR_HELD_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr)); // R5
  AST_DRIVE_NEEDS_WRITE_CTRL: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_cs_n && mem_oe_n)); // R6
  AST_DRIVE_AFTER_WE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(!mem_we_n)); // R6
  AST_WE_FALLS_IN_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(!mem_cs_n)); // R4
  AST_CS_HELD_AT_WE_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_we_n) && !$past(rst)) |-> !mem_cs_n); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R3
  AST_READY_PARKED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R2
  AST_STANDBY_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (standby_req && mem_cs_n) |=> mem_cs_n); // R9
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .standby_req(standby_req), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int RD  = 14;
  localparam int TA  = 6;
  localparam int WP  = 11;
  localparam int DS  = 6;
  localparam int DH  = 1;
  localparam int REC = 40;
  localparam int NV  = 9;
  // {write, addr[14:0], wdata, expected read}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 15'h0000, 8'hA5, 8'h00},
    {1'b1, 15'h7FFF, 8'h3C, 8'h00},
    {1'b0, 15'h0000, 8'h00, 8'hA5},
    {1'b0, 15'h7FFF, 8'h00, 8'h3C},
    {1'b1, 15'h1234, 8'h00, 8'h00},
    {1'b0, 15'h1234, 8'h00, 8'h00},
    {1'b0, 15'h4321, 8'h00, 8'h7B},
    {1'b1, 15'h1234, 8'hFF, 8'h00},
    {1'b0, 15'h1234, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] mem_dq_in = 8'hEE;
  logic [14:0] mem_addr;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.RD_CYC(RD), .TA_CYC(TA), .WP_CYC(WP), .DS_CYC(DS),
                    .DH_CYC(DH), .REC_CYC(REC)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .standby_req(standby_req),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // behavioural memory with protocol monitors, evaluated on falling edges
  logic [7:0] mem_arr [logic [14:0]];
  int acc = 0, tail = 0, pw = 0, dsn = 0;
  int v_overlap = 0, v_addr = 0, v_cont = 0, v_pulse = 0, v_setup = 0, v_hold = 0;
  logic prev_wr = 1'b0, prev_rd = 1'b0, rd_now, wr_now;
  logic [14:0] prev_addr = '0;
  logic [7:0] prev_dq = '0;

  function automatic logic [7:0] model_rd(input logic [14:0] a);
    if (mem_arr.exists(a)) return mem_arr[a];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    rd_now = !mem_cs_n && !mem_oe_n && mem_we_n;
    wr_now = !mem_cs_n && !mem_we_n;
    if (rst) begin
      acc = 0; tail = 0; pw = 0; dsn = 0;
      prev_wr = 1'b0; prev_rd = 1'b0;
      mem_dq_in = 8'hEE;
    end else begin
      if (!mem_cs_n && !mem_oe_n && !mem_we_n) v_overlap++;
      if (mem_dq_oe && (rd_now || tail > 0)) v_cont++;
      if (wr_now && prev_wr && mem_addr != prev_addr) v_addr++;
      if (wr_now) begin
        pw++;
        if (mem_dq_oe) dsn++;
      end
      if (!wr_now && prev_wr) begin
        if (pw < WP) v_pulse++;
        if (dsn < DS) v_setup++;
        if (!mem_dq_oe) v_hold++;
        mem_arr[prev_addr] = prev_dq;
        pw = 0; dsn = 0;
      end
      if (rd_now) tail = TA; else if (tail > 0) tail--;
      if (rd_now && prev_rd && mem_addr == prev_addr) acc++;
      else if (rd_now) acc = 1;
      else acc = 0;
      mem_dq_in = (acc >= RD) ? model_rd(mem_addr) : 8'hEE;
      prev_wr = wr_now; prev_rd = rd_now;
      prev_addr = mem_addr; prev_dq = mem_dq_out;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [14:0] a, input logic [7:0] d,
                       output int lat, output logic [7:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    rd = 8'h00;
    if (!w) begin
      while (!rsp_valid) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R3 one-cycle response", int'(rsp_valid), 0);
    end else begin
      while (!req_ready) begin @(negedge clk); lat++; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [7:0] rd;
    int bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state: {cs_n,oe_n,we_n,dq_oe,rsp_valid,ready}
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready} == 6'b111001,
        "R1 reset state",
        int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready}), 6'b111001);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][31], VEC[i][30:16], VEC[i][15:8], lat, rd);
      if (VEC[i][31]) begin
        chk(lat == 1 + WP + DH, "R4 write duration", lat, 1 + WP + DH);
      end else begin
        chk(rd == VEC[i][7:0], "R3 read data", int'(rd), int'(VEC[i][7:0]));
        chk(lat == RD, "R3 read latency", lat, RD);
      end
    end

    // R9: standby outranks a simultaneous request, ignores requests while held
    @(negedge clk);
    standby_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0000;
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 ready low in standby", int'(req_ready), 0);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!mem_cs_n || rsp_valid) bad++;
    end
    chk(bad == 0, "R9 deselected and requests ignored", bad, 0);
    req_valid = 1'b0;
    standby_req = 1'b0;
    // R10: first edge after release starts the count; ready visible REC+1 falling edges later
    lat = 0; bad = 0;
    while (!req_ready && lat < REC + 10) begin
      @(negedge clk);
      lat++;
      if (!mem_cs_n) bad++;
    end
    chk(lat == REC + 1, "R10 recovery length", lat, REC + 1);
    chk(bad == 0, "R10 chip select high in recovery", bad, 0);

    issue(1'b0, 15'h7FFF, 8'h00, lat, rd);
    chk(rd == 8'h3C, "R10 access after recovery", int'(rd), 8'h3C);

    // R11: reset inside a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0042; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(mem_we_n == 1'b0, "R11 write in progress", int'(mem_we_n), 0);
    rst = 1'b1;
    @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R11 strobes released",
        int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}), 4'b1110);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", int'(req_ready), 1);
    issue(1'b0, 15'h1234, 8'h00, lat, rd);
    chk(rd == 8'hFF, "R11 prior data intact", int'(rd), 8'hFF);

    repeat (4) @(negedge clk);
    chk(v_overlap == 0, "R8 strobe overlap events", v_overlap, 0);
    chk(v_addr == 0, "R5 address moves during write", v_addr, 0);
    chk(v_cont == 0, "R7 bus contention events", v_cont, 0);
    chk(v_pulse == 0, "R4 short write pulses", v_pulse, 0);
    chk(v_setup == 0, "R6 data setup shortfalls", v_setup, 0);
    chk(v_hold == 0, "R6 data hold shortfalls", v_hold, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule